// File: doc/BRIEF.md
# High-Side Switch Control and Status Register

This block is the register slice behind two high-side load switches. A serial command front end (not part of this block) delivers a 4-bit write nibble with a one-cycle strobe. The nibble sets, for each channel, a switch-enable bit and a PWM-gate bit. Each channel's switch-on output is on only while the channel is enabled. If its PWM-gate bit is also set, the output is further gated by an external PWM input that is synchronized into the clock domain first. Every output is registered.

On every accepted write the block captures a 4-bit status nibble and holds it for the serial front end to shift back. For each channel the nibble carries an open-load flag and a current-limit flag. An over-temperature event on a channel raises both of that channel's flags together, which is how thermal shutdown is reported. The control bits cannot be read back. They clear on the general reset, on reset-mode entry and on an external reset. A channel's bits also clear on that channel's over-temperature, and on a supply overvoltage while overvoltage shutdown is enabled.

Top module: `hs_switch_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `sw_on_o` and `stat_o` are all zero.
- R2: Write nibble fields: bit 0 enables channel 1, bit 1 enables channel 2, bit 2 is the PWM gate of channel 1, bit 3 is the PWM gate of channel 2.
- R3: A channel with its PWM gate clear drives `sw_on_o` equal to its enable bit, one clock after the write edge.
- R4: A channel with both enable and PWM gate set drives `sw_on_o` equal to `pwm_i`, delayed by three clock edges (two synchronizer stages plus the output register).
- R5: A channel whose enable bit is clear keeps `sw_on_o` low whatever `pwm_i` and its PWM gate are.
- R6: A one-cycle pulse on `mode_rst_i` or `ext_rst_i` clears all control bits and the status nibble. The outputs are low two edges later.
- R7: `ot_i[k]` clears only channel k's control bits, and it wins over a write in the same cycle. The other channel still takes the written value.
- R8: `ov_i` clears all control bits only while `ov_shdn_en_i` is high. With the enable low it has no effect.
- R9: Each write edge captures `stat_o` with bit 3 = channel 2 open-load, bit 2 = channel 2 current-limit, bit 1 = channel 1 open-load, bit 0 = channel 1 current-limit.
- R10: If `ot_i[k]` is high at a write edge, both status bits of channel k are captured as 1.
- R11: Between writes, `stat_o` holds its value while the fault and status inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| mode_rst_i | input | 1 | Reset-mode entry pulse, clears control and status |
| ext_rst_i | input | 1 | External reset pulse, clears control and status |
| wr_en_i | input | 1 | Write strobe from the serial front end |
| wr_data_i | input | 4 | Write nibble (pwm gates in bits 3:2, enables in bits 1:0) |
| ot_i | input | 2 | Per-channel over-temperature indication |
| ov_i | input | 1 | Supply overvoltage indication |
| ov_shdn_en_i | input | 1 | Allows overvoltage to shut the switches off |
| open_load_i | input | 2 | Per-channel open-load indication |
| cur_lim_i | input | 2 | Per-channel current-limit indication |
| pwm_i | input | 1 | Asynchronous external PWM input |
| sw_on_o | output | 2 | Registered switch-on command per channel |
| stat_o | output | 4 | Status nibble captured at the last write |

## Verification
The assertions assume that every input except `pwm_i` is synchronous to `clk` and changes only between edges. They also assume the reset pulses and fault flags are plain levels sampled at each edge, so a one-cycle pulse always takes effect. The bench drives all inputs on the falling edge, including `pwm_i`, so the synchronizer latency is exactly two edges and can be checked cycle by cycle. Fault and reset pulses last a single cycle, and the status inputs are changed between writes to exercise the hold behaviour.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int unsigned HS_CH        = 2;
  localparam int unsigned HS_SYNC_STGS = 2;
endpackage

// File: rtl/hs_pwm_sync.sv
module hs_pwm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];

  // R1: the synchronizer is flushed by reset
  a_r1_sync_flushed: assert property (@(posedge clk) rst |=> !q_o);
endmodule

// File: rtl/hs_ctrl_regs.sv
module hs_ctrl_regs #(
  parameter int unsigned NCH = 2,
  localparam int unsigned WW = 2 * NCH
) (
  input  logic           clk,
  input  logic           clr,
  input  logic           wr_en,
  input  logic [WW-1:0]  wr_data,
  input  logic [NCH-1:0] ot,
  input  logic           ov_trip,
  output logic [NCH-1:0] en_q,
  output logic [NCH-1:0] pen_q
);
  for (genvar k = 0; k < NCH; k++) begin : g_ch
    always_ff @(posedge clk) begin
      if (clr || ot[k] || ov_trip) begin
        en_q[k]  <= 1'b0;
        pen_q[k] <= 1'b0;
      end else if (wr_en) begin
        en_q[k]  <= wr_data[k];
        pen_q[k] <= wr_data[NCH + k];
      end
    end

    // R7: a channel's over-temperature clears that channel
    a_r7_ot_clears: assert property (@(posedge clk) disable iff (clr)
      ot[k] |=> (!en_q[k] && !pen_q[k]));

    // R2: a clean write loads the fields of this channel
    a_r2_write_loads: assert property (@(posedge clk) disable iff (clr)
      (wr_en && !ot[k] && !ov_trip) |=>
        (en_q[k] == $past(wr_data[k]) && pen_q[k] == $past(wr_data[NCH + k])));
  end

  // R8: enabled overvoltage clears every channel
  a_r8_ov_clears: assert property (@(posedge clk) disable iff (clr)
    ov_trip |=> (en_q == '0 && pen_q == '0));
endmodule

// File: rtl/hs_status_cap.sv
module hs_status_cap #(
  parameter int unsigned NCH = 2,
  localparam int unsigned SW = 2 * NCH
) (
  input  logic           clk,
  input  logic           clr,
  input  logic           wr_en,
  input  logic [NCH-1:0] ol,
  input  logic [NCH-1:0] cl,
  input  logic [NCH-1:0] ot,
  output logic [SW-1:0]  stat_q
);
  logic [SW-1:0] stat_d;

  for (genvar k = 0; k < NCH; k++) begin : g_pack
    assign stat_d[2*k+1] = ol[k] | ot[k];
    assign stat_d[2*k]   = cl[k] | ot[k];

    // R10: thermal shutdown shows as both flags of the channel
    a_r10_thermal_pair: assert property (@(posedge clk) disable iff (clr)
      (wr_en && ot[k]) |=> (stat_q[2*k+1] && stat_q[2*k]));
  end

  always_ff @(posedge clk) begin
    if (clr)        stat_q <= '0;
    else if (wr_en) stat_q <= stat_d;
  end

  // R11: the captured nibble holds between writes
  a_r11_hold: assert property (@(posedge clk) disable iff (clr)
    !wr_en |=> $stable(stat_q));
endmodule

// File: rtl/hs_switch_ctrl.sv
module hs_switch_ctrl
  import hs_pkg::*;
#(
  parameter int unsigned NCH  = HS_CH,
  parameter int unsigned SYNC = HS_SYNC_STGS,
  localparam int unsigned WW  = 2 * NCH
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mode_rst_i,
  input  logic           ext_rst_i,
  input  logic           wr_en_i,
  input  logic [WW-1:0]  wr_data_i,
  input  logic [NCH-1:0] ot_i,
  input  logic           ov_i,
  input  logic           ov_shdn_en_i,
  input  logic [NCH-1:0] open_load_i,
  input  logic [NCH-1:0] cur_lim_i,
  input  logic           pwm_i,
  output logic [NCH-1:0] sw_on_o,
  output logic [WW-1:0]  stat_o
);
  logic           clr_all;
  logic           ov_trip;
  logic           pwm_s;
  logic [NCH-1:0] en_q;
  logic [NCH-1:0] pen_q;

  assign clr_all = rst | mode_rst_i | ext_rst_i;
  assign ov_trip = ov_i & ov_shdn_en_i;

  hs_pwm_sync #(.STAGES(SYNC)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pwm_i),
    .q_o (pwm_s)
  );

  hs_ctrl_regs #(.NCH(NCH)) u_ctrl (
    .clk     (clk),
    .clr     (clr_all),
    .wr_en   (wr_en_i),
    .wr_data (wr_data_i),
    .ot      (ot_i),
    .ov_trip (ov_trip),
    .en_q    (en_q),
    .pen_q   (pen_q)
  );

  hs_status_cap #(.NCH(NCH)) u_stat (
    .clk    (clk),
    .clr    (clr_all),
    .wr_en  (wr_en_i),
    .ol     (open_load_i),
    .cl     (cur_lim_i),
    .ot     (ot_i),
    .stat_q (stat_o)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_out
    always_ff @(posedge clk) begin
      if (clr_all) sw_on_o[k] <= 1'b0;
      else         sw_on_o[k] <= en_q[k] & (~pen_q[k] | pwm_s);
    end

    // R5: a disabled channel is off on the next edge
    a_r5_gated_off: assert property (@(posedge clk) disable iff (rst)
      !en_q[k] |=> !sw_on_o[k]);

    // R3: ungated enabled channel is on on the next edge
    a_r3_follow_en: assert property (@(posedge clk) disable iff (rst)
      (en_q[k] && !pen_q[k] && !mode_rst_i && !ext_rst_i) |=> sw_on_o[k]);
  end

  // R6: reset-mode and external reset clear the control state
  a_r6_soft_reset: assert property (@(posedge clk) disable iff (rst)
    (mode_rst_i || ext_rst_i) |=> (en_q == '0 && pen_q == '0 && stat_o == '0));

  // R1: reset leaves outputs low
  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> (sw_on_o == '0 && stat_o == '0));
endmodule

// File: tb/sim_hs_switch_ctrl.sv
`timescale 1ns/1ps
module sim_hs_switch_ctrl;
  logic       clk = 1'b0;
  logic       rst, mode_rst, ext_rst, wr_en, ov, ov_en, pwm;
  logic [3:0] wdata;
  logic [1:0] ot, ol, cl, sw_on;
  logic [3:0] stat;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done  = 1'b0;

  always #10 clk = ~clk;

  hs_switch_ctrl u0 (
    .clk (clk), .rst (rst), .mode_rst_i (mode_rst), .ext_rst_i (ext_rst),
    .wr_en_i (wr_en), .wr_data_i (wdata), .ot_i (ot), .ov_i (ov),
    .ov_shdn_en_i (ov_en), .open_load_i (ol), .cur_lim_i (cl),
    .pwm_i (pwm), .sw_on_o (sw_on), .stat_o (stat)
  );

  // {wdata[14:11], pwm[10], ol[9:8], cl[7:6], exp_sw[5:4], exp_stat[3:0]}
  localparam int NV = 9;
  localparam logic [14:0] VEC [NV] = '{
    {4'b0001, 1'b0, 2'b00, 2'b00, 2'b01, 4'b0000},
    {4'b0010, 1'b0, 2'b01, 2'b00, 2'b10, 4'b0010},
    {4'b0011, 1'b0, 2'b10, 2'b01, 2'b11, 4'b1001},
    {4'b0111, 1'b0, 2'b00, 2'b10, 2'b10, 4'b0100},
    {4'b0111, 1'b1, 2'b00, 2'b00, 2'b11, 4'b0000},
    {4'b1011, 1'b0, 2'b00, 2'b00, 2'b01, 4'b0000},
    {4'b1100, 1'b1, 2'b11, 2'b11, 2'b00, 4'b1111},
    {4'b1111, 1'b1, 2'b00, 2'b00, 2'b11, 4'b0000},
    {4'b1111, 1'b0, 2'b00, 2'b00, 2'b00, 4'b0000}
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic write(input logic [3:0] d);
    wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; mode_rst = 0; ext_rst = 0; wr_en = 1'b1; wdata = 4'hF;
    ot = 0; ov = 0; ov_en = 0; pwm = 1'b1; ol = 2'b11; cl = 2'b11;
    settle(3);
    chk("R1 sw during reset", {2'b00, sw_on}, 4'b0000);
    chk("R1 stat during reset", stat, 4'b0000);
    rst = 1'b0; wr_en = 1'b0; ol = 0; cl = 0; pwm = 1'b0;
    settle(1);
    chk("R1 sw after reset", {2'b00, sw_on}, 4'b0000);

    // vector walk: R2 R3 R4 R5 on outputs, R9 R10 on status
    for (int i = 0; i < NV; i++) begin
      pwm = VEC[i][10]; ol = VEC[i][9:8]; cl = VEC[i][7:6];
      write(VEC[i][14:11]);
      settle(3);
      chk($sformatf("R2 R3 R4 R5 vector %0d sw", i), {2'b00, sw_on}, {2'b00, VEC[i][5:4]});
      chk($sformatf("R9 vector %0d stat", i), stat, VEC[i][3:0]);
    end

    // R4 latency and R11 hold: both channels gated, pwm low
    pwm = 1'b0; ol = 0; cl = 0;
    write(4'b1111);
    settle(3);
    chk("R4 gated low", {2'b00, sw_on}, 4'b0000);
    pwm = 1'b1; ol = 2'b11; cl = 2'b10; ot = 2'b00;
    settle(2);
    chk("R4 not yet through sync", {2'b00, sw_on}, 4'b0000);
    settle(1);
    chk("R4 through after three edges", {2'b00, sw_on}, 4'b0011);
    chk("R11 stat held", stat, 4'b0000);
    ol = 0; cl = 0;

    // R5: pwm gate set, enables clear, pwm toggling
    write(4'b1100);
    for (int j = 0; j < 4; j++) begin
      pwm = ~pwm;
      settle(3);
      chk("R5 disabled stays off", {2'b00, sw_on}, 4'b0000);
    end

    // R6: reset-mode entry
    write(4'b0011);
    settle(2);
    chk("R6 precondition on", {2'b00, sw_on}, 4'b0011);
    mode_rst = 1'b1; settle(1); mode_rst = 1'b0;
    settle(1);
    chk("R6 mode reset off", {2'b00, sw_on}, 4'b0000);
    // R6: external reset also clears status
    ol = 2'b01;
    write(4'b0011);
    ol = 0;
    settle(1);
    chk("R6 stat before ext reset", stat, 4'b0010);
    ext_rst = 1'b1; settle(1); ext_rst = 1'b0;
    settle(1);
    chk("R6 ext reset off", {2'b00, sw_on}, 4'b0000);
    chk("R6 ext reset stat", stat, 4'b0000);

    // R7 and R10: channel 1 over-temperature during a write
    pwm = 1'b1;
    settle(3);
    ot = 2'b01;
    write(4'b1111);
    ot = 2'b00;
    settle(2);
    chk("R7 only channel 2 on", {2'b00, sw_on}, 4'b0010);
    chk("R10 thermal pair", stat, 4'b0011);

    // R8: overvoltage without shutdown enable
    write(4'b0011);
    ov = 1'b1; ov_en = 1'b0;
    settle(3);
    chk("R8 ov ignored", {2'b00, sw_on}, 4'b0011);
    ov_en = 1'b1; settle(1); ov_en = 1'b0; ov = 1'b0;
    settle(1);
    chk("R8 ov shutdown", {2'b00, sw_on}, 4'b0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule